// File: doc/BRIEF.md
# Shared-Prescaler Timer and Watchdog

This block holds an 8-bit up-counting timer and a watchdog counter that take turns using a single 8-bit prescaler. A control input hands the prescaler to one of the two. The owner counts through a divide ratio chosen by a 3-bit select. The other counter is fed its source ticks directly, at 1:1. The timer counts either the instruction clock, which is the core clock divided by two, or rising edges of a slow low-frequency clock. That slow clock is brought into the core clock domain through a two-stage synchronizer and an edge detector. The watchdog base counter always runs from the synchronized slow clock.

Software loads the timer with a write strobe, and every load also empties the prescaler. Two instruction strobes, watchdog-clear and sleep, empty the prescaler only while the watchdog owns it. The watchdog-clear strobe also restarts the watchdog count. When the timer wraps past its maximum it sets a sticky overflow flag. When the watchdog count wraps while the watchdog is enabled, the block emits a one-cycle timeout pulse. Every pin is a plain level or strobe; nothing streams in or out, so there is no back-pressure.

Top module: `tw_share_timer`

## Requirements
- R1: After reset, tmr_count is 0, ovf_flag is 0 and wd_timeout is 0.
- R2: A tmr_wr_en strobe loads tmr_wr_data into tmr_count on the next edge. Whatever the owner, it clears the prescaler, and it takes priority over a tick in the same cycle.
- R3: When own_wdog=0 (timer owns the prescaler), tmr_count advances once per 2^(div_sel+1) timer source ticks, a ratio of 1:2 for div_sel=0 up to 1:256 for div_sel=7.
- R4: The counter that does not own the prescaler runs at 1:1. With own_wdog=1 the timer advances on every source tick, and with own_wdog=0 the watchdog advances on every slow-clock edge.
- R5: When own_wdog=1 the watchdog advances once per 2^div_sel slow-clock edges. After the watchdog count wraps from 2^WDOG_W-1 to 0, wd_timeout is high for exactly one cycle.
- R6: While own_wdog=1, a wdog_clr or sleep_stb strobe clears the prescaler. A wdog_clr strobe clears the watchdog count under either owner, and no timeout is raised in the cycle after it.
- R7: While own_wdog=0, a sleep_stb strobe leaves the prescaler count untouched.
- R8: A timer wrap from 0xFF to 0x00 sets ovf_flag. The flag stays set until ovf_clr is pulsed, and a wrap in the same cycle as ovf_clr leaves it set.
- R9: wd_timeout never goes high while wd_en is low.
- R10: With tmr_src_lf=0 the timer source ticks once every two core clocks. With tmr_src_lf=1 the source ticks once per rising edge of lf_clk, after a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lf_clk | input | 1 | Low-frequency clock, asynchronous to clk |
| tmr_wr_en | input | 1 | Timer load strobe |
| tmr_wr_data | input | 8 | Timer load value |
| tmr_src_lf | input | 1 | Timer source: 0 instruction clock, 1 slow clock |
| own_wdog | input | 1 | Prescaler owner: 0 timer, 1 watchdog |
| div_sel | input | 3 | Prescaler ratio select |
| wd_en | input | 1 | Watchdog timeout enable |
| wdog_clr | input | 1 | Watchdog-clear instruction strobe |
| sleep_stb | input | 1 | Sleep instruction strobe |
| ovf_clr | input | 1 | Clears the overflow flag |
| tmr_count | output | 8 | Current timer value |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| wd_timeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The bench counts exact numbers of slow-clock edges between strobes, so an off-by-one ratio shows up as a wrong timer value or as a timeout one edge early or late. It places a sleep strobe partway through a prescaler period under each owner. If the clear rule were applied to the wrong owner, the timer would lose a count, or the watchdog would fire one base tick too soon. It also loads the timer partway through a period, where a design that kept the prescaler would count one too many. It wraps the timer and lets the watchdog pass its wrap point with the enable low, so a flag that never sets or a timeout that ignores the enable is exposed.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic {
    OWN_TMR  = 1'b0,
    OWN_WDOG = 1'b1
  } pre_owner_e;

  localparam int TW_TMR_W  = 8;
  localparam int TW_PRE_W  = 8;
  localparam int TW_SEL_W  = 3;
  localparam int TW_WDOG_W = 8;
endpackage

// File: rtl/tw_edge_sync.sv
module tw_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_tick
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_tick = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int PRE_W = 8,
  localparam int SH_W = $clog2(PRE_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            in_tick,
  input  logic [SH_W-1:0] shift,
  output logic            out_tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    localparam logic [SH_W-1:0] IDX = SH_W'(i);
    assign mask[i] = (IDX < shift);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (in_tick) cnt_q <= cnt_q + 1'b1;
  end

  assign out_tick = in_tick & ~clr & ((cnt_q & mask) == mask);
endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TMR_W-1:0] wr_data,
  input  logic             tick,
  input  logic             ovf_clr,
  output logic [TMR_W-1:0] count,
  output logic             ovf_flag
);
  logic wrap;

  assign wrap = tick & ~wr_en & (count == {TMR_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (wr_en) count <= wr_data;
    else if (tick)  count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (wrap)    ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/tw_wdog.sv
module tw_wdog #(
  parameter int WDOG_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic en,
  output logic timeout
);
  logic [WDOG_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) timeout <= 1'b0;
    else        timeout <= en & tick & ~clr & (cnt_q == {WDOG_W{1'b1}});
  end
endmodule

// File: rtl/tw_share_timer.sv
module tw_share_timer
  import tw_pkg::*;
#(
  parameter int TMR_W  = TW_TMR_W,
  parameter int PRE_W  = TW_PRE_W,
  parameter int SEL_W  = TW_SEL_W,
  parameter int WDOG_W = TW_WDOG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lf_clk,
  input  logic             tmr_wr_en,
  input  logic [TMR_W-1:0] tmr_wr_data,
  input  logic             tmr_src_lf,
  input  logic             own_wdog,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             wd_en,
  input  logic             wdog_clr,
  input  logic             sleep_stb,
  input  logic             ovf_clr,
  output logic [TMR_W-1:0] tmr_count,
  output logic             ovf_flag,
  output logic             wd_timeout
);
  localparam int SH_W = $clog2(PRE_W + 1);

  pre_owner_e      owner;
  logic            icyc_q;
  logic            lf_tick;
  logic            src_tick;
  logic            pre_in;
  logic            pre_out;
  logic            pre_clr;
  logic [SH_W-1:0] shift;
  logic            tmr_tick;
  logic            wd_tick;

  assign owner = own_wdog ? OWN_WDOG : OWN_TMR;

  // instruction clock enable: core clock divided by two
  always_ff @(posedge clk) begin
    if (!rst_n) icyc_q <= 1'b0;
    else        icyc_q <= ~icyc_q;
  end

  tw_edge_sync #(.STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  (lf_clk),
    .rise_tick (lf_tick)
  );

  assign src_tick = tmr_src_lf ? lf_tick : icyc_q;

  always_comb begin
    pre_in   = src_tick;
    shift    = SH_W'(div_sel) + SH_W'(1);
    tmr_tick = pre_out;
    wd_tick  = lf_tick;
    pre_clr  = tmr_wr_en;
    if (owner == OWN_WDOG) begin
      pre_in   = lf_tick;
      shift    = SH_W'(div_sel);
      tmr_tick = src_tick;
      wd_tick  = pre_out;
      pre_clr  = tmr_wr_en | wdog_clr | sleep_stb;
    end
  end

  tw_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pre_clr),
    .in_tick  (pre_in),
    .shift    (shift),
    .out_tick (pre_out)
  );

  tw_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tmr_wr_en),
    .wr_data  (tmr_wr_data),
    .tick     (tmr_tick),
    .ovf_clr  (ovf_clr),
    .count    (tmr_count),
    .ovf_flag (ovf_flag)
  );

  tw_wdog #(.WDOG_W(WDOG_W)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (wdog_clr),
    .tick    (wd_tick),
    .en      (wd_en),
    .timeout (wd_timeout)
  );
endmodule

// File: rtl/tw_share_timer_chk.sv
module tw_share_timer_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_wr_en,
  input logic [TMR_W-1:0] tmr_wr_data,
  input logic             ovf_clr,
  input logic             wd_en,
  input logic             wdog_clr,
  input logic [TMR_W-1:0] tmr_count,
  input logic             ovf_flag,
  input logic             wd_timeout
);
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr_en |=> tmr_count == $past(tmr_wr_data)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_wr_en |=> (tmr_count == $past(tmr_count)) ||
                   (tmr_count == TMR_W'($past(tmr_count) + 1'b1))); // R3

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_wr_en && tmr_count == {TMR_W{1'b1}}) |=>
      (tmr_count == {TMR_W{1'b1}}) || ovf_flag); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R8

  AST_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_timeout |=> !wd_timeout); // R5

  AST_TO_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_clr |=> !wd_timeout); // R6

  AST_TO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> !wd_timeout); // R9
endmodule

bind tw_share_timer tw_share_timer_chk #(.TMR_W(TMR_W)) u_chk (.*);

// File: tb/tw_share_timer_bench.sv
module tw_share_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lf_clk = 1'b0;
  logic       tmr_wr_en = 1'b0;
  logic [7:0] tmr_wr_data = '0;
  logic       tmr_src_lf = 1'b1;
  logic       own_wdog = 1'b1;
  logic [2:0] div_sel = '0;
  logic       wd_en = 1'b0;
  logic       wdog_clr = 1'b0;
  logic       sleep_stb = 1'b0;
  logic       ovf_clr = 1'b0;
  logic [7:0] tmr_count;
  logic       ovf_flag;
  logic       wd_timeout;

  int n_chk = 0;
  int n_bad = 0;
  int to_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_share_timer u_tw_share_timer (
    .clk(clk), .rst_n(rst_n), .lf_clk(lf_clk),
    .tmr_wr_en(tmr_wr_en), .tmr_wr_data(tmr_wr_data),
    .tmr_src_lf(tmr_src_lf), .own_wdog(own_wdog), .div_sel(div_sel),
    .wd_en(wd_en), .wdog_clr(wdog_clr), .sleep_stb(sleep_stb),
    .ovf_clr(ovf_clr), .tmr_count(tmr_count), .ovf_flag(ovf_flag),
    .wd_timeout(wd_timeout)
  );

  always @(negedge clk) if (rst_n && wd_timeout) to_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lf_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) lf_clk = 1'b1;
      idle(3);
      lf_clk = 1'b0;
      idle(3);
    end
    idle(6);
  endtask

  task automatic wr_tmr(input logic [7:0] v);
    @(negedge clk) begin tmr_wr_en = 1'b1; tmr_wr_data = v; end
    @(negedge clk) tmr_wr_en = 1'b0;
    idle(2);
  endtask

  task automatic pulse_clr();
    @(negedge clk) wdog_clr = 1'b1;
    @(negedge clk) wdog_clr = 1'b0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk) sleep_stb = 1'b1;
    @(negedge clk) sleep_stb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", tmr_count, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 timeout", wd_timeout, 0);
  endtask

  task automatic t_source();
    int v;
    own_wdog = 1'b1; tmr_src_lf = 1'b0;
    wr_tmr(8'd0);
    idle(200);
    v = tmr_count;
    chk("R10 instr clock near 100", int'(v >= 99 && v <= 101), 1);
    tmr_src_lf = 1'b1;
    wr_tmr(8'd0);
    lf_edges(10);
    chk("R10 slow clock edges", tmr_count, 10);
    chk("R4 timer bypass 1:1", tmr_count, 10);
  endtask

  task automatic t_ratio();
    own_wdog = 1'b0; tmr_src_lf = 1'b1;
    for (int s = 0; s < 8; s++) begin
      div_sel = 3'(s);
      wr_tmr(8'd0);
      lf_edges(256);
      chk($sformatf("R3 ratio sel=%0d", s), tmr_count, 256 >> (s + 1));
    end
  endtask

  task automatic t_write_clears();
    own_wdog = 1'b0; div_sel = 3'd2;
    wr_tmr(8'd0);
    lf_edges(5);
    wr_tmr(8'h10);
    chk("R2 load value", tmr_count, 16);
    lf_edges(3);
    chk("R2 prescaler cleared by load", tmr_count, 16);
    lf_edges(5);
    chk("R2 full period after load", tmr_count, 17);
  endtask

  task automatic t_sleep_tmr();
    own_wdog = 1'b0; div_sel = 3'd2;
    wr_tmr(8'd0);
    lf_edges(5);
    pulse_sleep();
    lf_edges(3);
    chk("R7 sleep keeps timer prescaler", tmr_count, 1);
  endtask

  task automatic t_wdog_bypass();
    int base;
    own_wdog = 1'b0; wd_en = 1'b1;
    pulse_clr();
    base = to_cnt;
    lf_edges(255);
    chk("R4 wdog 1:1 before wrap", to_cnt - base, 0);
    lf_edges(1);
    chk("R4 wdog 1:1 at wrap", to_cnt - base, 1);
  endtask

  task automatic t_wdog_ratio();
    int base;
    own_wdog = 1'b1; div_sel = 3'd1; wd_en = 1'b1;
    pulse_clr();
    base = to_cnt;
    lf_edges(511);
    chk("R5 wdog 1:2 before wrap", to_cnt - base, 0);
    lf_edges(1);
    chk("R5 single pulse at wrap", to_cnt - base, 1);
    pulse_clr();
    base = to_cnt;
    lf_edges(1);
    pulse_sleep();
    lf_edges(511);
    chk("R6 sleep clears wdog prescaler", to_cnt - base, 0);
    lf_edges(1);
    chk("R6 timeout after sleep restart", to_cnt - base, 1);
  endtask

  task automatic t_wdog_clear();
    int base;
    own_wdog = 1'b0; wd_en = 1'b1;
    pulse_clr();
    base = to_cnt;
    lf_edges(200);
    pulse_clr();
    lf_edges(200);
    chk("R6 clear restarts wdog", to_cnt - base, 0);
    lf_edges(56);
    chk("R6 timeout 256 after clear", to_cnt - base, 1);
  endtask

  task automatic t_wdog_disable();
    int base;
    own_wdog = 1'b0; wd_en = 1'b0;
    pulse_clr();
    base = to_cnt;
    lf_edges(300);
    chk("R9 no timeout when disabled", to_cnt - base, 0);
  endtask

  task automatic t_overflow();
    own_wdog = 1'b1; tmr_src_lf = 1'b1;
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    wr_tmr(8'hFE);
    lf_edges(1);
    chk("R8 no flag before wrap", ovf_flag, 0);
    lf_edges(1);
    chk("R8 wrapped to zero", tmr_count, 0);
    chk("R8 flag set on wrap", ovf_flag, 1);
    lf_edges(3);
    chk("R8 flag sticky", ovf_flag, 1);
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    chk("R8 flag cleared", ovf_flag, 0);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_source();
    t_ratio();
    t_write_clears();
    t_sleep_tmr();
    t_wdog_bypass();
    t_wdog_ratio();
    t_wdog_clear();
    t_wdog_disable();
    t_overflow();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule